// File: doc/BRIEF.md
# Fused Micro-Op Decoder for RV32I

This block looks at a fetch window of up to four consecutive 32-bit RV32I instructions, together with the address of the first, and folds the front of that window into a single micro-op. Every micro-op it produces acts as a jump. It has an explicit next address, and branch micro-ops also hold a second address that is used when the branch falls through. Because of this, a trailing unconditional jump can vanish into the operation before it, and a branch resolves by picking one of two stored addresses.

The decoder recognises four kinds of pattern:
- An upper-immediate load followed by an add-immediate on the same register becomes one full 32-bit immediate load.
- An unconditional jump with no link, placed right after a load-immediate or add-immediate micro-op, is absorbed into that micro-op's next address.
- A conditional branch becomes a two-target micro-op.
- A jump-and-link becomes a register-set-plus-jump micro-op.

Any other instruction passes through unchanged as a one-instruction micro-op. The output is registered and follows an accepted window by one clock. It also reports how many instructions the micro-op used up, so the fetch side can advance.

Top module: `rvf_fuse_decoder`

## Requirements
- R1: After synchronous reset `uop_valid` is 0. Each cycle `uop_valid` equals `in_valid` of the cycle before, and the micro-op fields belong to that window.
- R2: An upper-immediate load (opcode 0110111) in slot 0, followed by an add-immediate (opcode 0010011, funct3 000) in slot 1 whose rd and rs1 both equal the load's rd, gives op LI (1). Its imm is {imm20,12'b0} plus the sign-extended 12-bit immediate, its rd is the shared register, and it consumes 2.
- R3: If the add-immediate's rd or rs1 differs from the load's rd, the pair is not fused. The result is op LI with imm {imm20,12'b0}, consuming 1.
- R4: A jump-and-link (opcode 1101111) with rd = x0 can sit in the slot right after an LI or ADDI micro-op. It is then absorbed: next_pc becomes that jump's own address plus its sign-extended J-type offset, and consumed grows by one. This stacks with R2, so consumed can reach 3.
- R5: A jump-and-link with rd ≠ x0 is never absorbed. At slot 0 it becomes op LI with rd = link register, imm = pc+4, next_pc = pc + J offset, consuming 1.
- R6: A jump-and-link with rd = x0 at slot 0 becomes op JMP (4) with next_pc = pc + J offset, consuming 1.
- R7: A conditional branch (opcode 1100011) at slot 0 becomes op BR (3) and consumes 1; no jump after it is absorbed. Its fields are:
  - rs1 = rs1, rd = 0, imm = {24'b0, funct3, rs2};
  - next_pc = pc + sign-extended B offset (the taken target);
  - alt_pc = pc+4 (the not-taken path).
- R8: Any other instruction becomes op PASS (0) and consumes 1. Its fields are imm = the raw instruction word, rs1 = bits 19:15 and rd = bits 11:7.
- R9: When no jump is absorbed and the op is not JMP, BR or a link-writing LI, next_pc = pc + 4·consumed. For every op other than BR, alt_pc equals next_pc.
- R10: An add-immediate at slot 0 that is not fused with a preceding load becomes op ADDI (2), with rs1, rd and imm = sign-extended 12-bit immediate.
- R11: Slots at index ≥ `win_count` (1..4) are ignored. They neither complete an R2 pair nor get absorbed under R4, and consumed never exceeds `win_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A window is presented this cycle |
| win_pc | input | 32 | Address of slot 0 |
| win_insn | input | 128 | Slot k at bits 32k+31:32k |
| win_count | input | 3 | Number of valid slots, 1..4 |
| uop_valid | output | 1 | Micro-op below is valid |
| uop_op | output | 3 | 0 PASS, 1 LI, 2 ADDI, 3 BR, 4 JMP |
| uop_rs1 | output | 5 | First source register |
| uop_imm | output | 32 | Immediate or second-operand field |
| uop_rd | output | 5 | Destination register |
| uop_next_pc | output | 32 | Address followed after this micro-op (taken target for BR) |
| uop_alt_pc | output | 32 | Not-taken address for BR, else equal to next_pc |
| uop_consumed | output | 3 | Instructions used from the window |

## Verification
The immediate-pair fusion and the trailing-jump absorption can act on the same window. A window of load-upper, matching add-immediate and an unlinked jump makes both fire together. The result is judged by three things: the combined 32-bit constant, a next address computed from the jump's own slot address (pc+8) rather than from slot 0, and a consumed count of 3. Neighbouring windows cover the cases just outside it: the jump carrying a link, the jump lying beyond `win_count`, and the pair with mismatched registers.

// File: rtl/rvf_pkg.sv
package rvf_pkg;

  localparam int ILEN = 32;

  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;

  typedef enum logic [2:0] {
    UOP_PASS = 3'd0,
    UOP_LI   = 3'd1,
    UOP_ADDI = 3'd2,
    UOP_BR   = 3'd3,
    UOP_JMP  = 3'd4
  } uop_op_e;

  typedef struct packed {
    logic            is_lui;
    logic            is_addi;
    logic            is_br;
    logic            is_jal;
    logic [4:0]      rd;
    logic [4:0]      rs1;
    logic [4:0]      rs2;
    logic [2:0]      funct3;
    logic [ILEN-1:0] raw;
    logic [31:0]     imm_u;
    logic [31:0]     imm_i;
    logic [31:0]     imm_b;
    logic [31:0]     imm_j;
  } slot_t;

  typedef struct packed {
    uop_op_e     op;
    logic [4:0]  rs1;
    logic [4:0]  rd;
    logic [31:0] imm;
    logic [31:0] next_pc;
    logic [31:0] alt_pc;
  } uop_t;

endpackage

// File: rtl/rvf_slot_dec.sv
module rvf_slot_dec
  import rvf_pkg::*;
(
  input  logic [ILEN-1:0] insn,
  output slot_t           info
);

  logic [6:0] opc;
  assign opc = insn[6:0];

  always_comb begin
    info         = '0;
    info.raw     = insn;
    info.rd      = insn[11:7];
    info.rs1     = insn[19:15];
    info.rs2     = insn[24:20];
    info.funct3  = insn[14:12];
    info.is_lui  = (opc == OPC_LUI);
    info.is_addi = (opc == OPC_OPIMM) && (insn[14:12] == 3'b000);
    info.is_br   = (opc == OPC_BRANCH);
    info.is_jal  = (opc == OPC_JAL);
    info.imm_u   = {insn[31:12], 12'b0};
    info.imm_i   = {{20{insn[31]}}, insn[31:20]};
    info.imm_b   = {{19{insn[31]}}, insn[31], insn[7], insn[30:25], insn[11:8], 1'b0};
    info.imm_j   = {{11{insn[31]}}, insn[31], insn[19:12], insn[20], insn[30:21], 1'b0};
  end

endmodule

// File: rtl/rvf_fuse_core.sv
module rvf_fuse_core
  import rvf_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int CNT_W = $clog2(NUM_SLOTS + 1)
) (
  input  slot_t [NUM_SLOTS-1:0] slots,
  input  logic  [NUM_SLOTS-1:0] slot_vld,
  input  logic  [31:0]          pc,
  output uop_t                  uop,
  output logic  [CNT_W-1:0]     consumed
);

  logic             pair_ok;
  logic             fusible;
  logic             absorbed;
  logic [CNT_W-1:0] head_len;
  logic [31:0]      seq_pc;
  logic [31:0]      jump_pc;

  // Immediate pair: both operands of the add must name the load's target.
  assign pair_ok = slots[0].is_lui && slot_vld[1] && slots[1].is_addi &&
                   (slots[1].rs1 == slots[0].rd) && (slots[1].rd == slots[0].rd);

  // Head operation selection, highest priority first.
  always_comb begin
    uop      = '0;
    uop.op   = UOP_PASS;
    head_len = CNT_W'(1);
    fusible  = 1'b0;
    if (pair_ok) begin
      uop.op   = UOP_LI;
      uop.rd   = slots[0].rd;
      uop.imm  = slots[0].imm_u + slots[1].imm_i;
      head_len = CNT_W'(2);
      fusible  = 1'b1;
    end else if (slots[0].is_lui) begin
      uop.op  = UOP_LI;
      uop.rd  = slots[0].rd;
      uop.imm = slots[0].imm_u;
      fusible = 1'b1;
    end else if (slots[0].is_addi) begin
      uop.op  = UOP_ADDI;
      uop.rd  = slots[0].rd;
      uop.rs1 = slots[0].rs1;
      uop.imm = slots[0].imm_i;
      fusible = 1'b1;
    end else if (slots[0].is_br) begin
      uop.op  = UOP_BR;
      uop.rs1 = slots[0].rs1;
      uop.imm = {24'b0, slots[0].funct3, slots[0].rs2};
    end else if (slots[0].is_jal) begin
      if (slots[0].rd == 5'd0) begin
        uop.op = UOP_JMP;
      end else begin
        uop.op  = UOP_LI;
        uop.rd  = slots[0].rd;
        uop.imm = pc + 32'd4;
      end
    end else begin
      uop.rs1 = slots[0].rs1;
      uop.rd  = slots[0].rd;
      uop.imm = slots[0].raw;
    end

    // Next-address resolution.
    seq_pc = pc + {{(32-CNT_W-2){1'b0}}, head_len, 2'b00};
    if (slots[0].is_br) begin
      uop.next_pc = pc + slots[0].imm_b;
      uop.alt_pc  = pc + 32'd4;
    end else if (slots[0].is_jal) begin
      uop.next_pc = pc + slots[0].imm_j;
      uop.alt_pc  = pc + slots[0].imm_j;
    end else begin
      uop.next_pc = seq_pc;
      uop.alt_pc  = seq_pc;
    end
    if (absorbed) begin
      uop.next_pc = jump_pc;
      uop.alt_pc  = jump_pc;
    end
    consumed = head_len + {{(CNT_W-1){1'b0}}, absorbed};
  end

  // Trailing unlinked jump directly after a fusible head.
  always_comb begin
    absorbed = 1'b0;
    jump_pc  = '0;
    for (int k = 1; k < NUM_SLOTS; k++) begin
      if (fusible && (head_len == CNT_W'(k)) && slot_vld[k] &&
          slots[k].is_jal && (slots[k].rd == 5'd0)) begin
        absorbed = 1'b1;
        jump_pc  = pc + 32'(k * 4) + slots[k].imm_j;
      end
    end
  end

endmodule

// File: rtl/rvf_fuse_decoder.sv
module rvf_fuse_decoder
  import rvf_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int CNT_W = $clog2(NUM_SLOTS + 1),
  localparam int WIN_W = NUM_SLOTS * ILEN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       win_pc,
  input  logic [WIN_W-1:0]  win_insn,
  input  logic [CNT_W-1:0]  win_count,
  output logic              uop_valid,
  output logic [2:0]        uop_op,
  output logic [4:0]        uop_rs1,
  output logic [31:0]       uop_imm,
  output logic [4:0]        uop_rd,
  output logic [31:0]       uop_next_pc,
  output logic [31:0]       uop_alt_pc,
  output logic [CNT_W-1:0]  uop_consumed
);

  slot_t [NUM_SLOTS-1:0] slots;
  logic  [NUM_SLOTS-1:0] slot_vld;
  uop_t                  uop_c;
  logic  [CNT_W-1:0]     cons_c;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    rvf_slot_dec u_dec (
      .insn (win_insn[g*ILEN +: ILEN]),
      .info (slots[g])
    );
    assign slot_vld[g] = (CNT_W'(g) < win_count);
  end

  rvf_fuse_core #(.NUM_SLOTS(NUM_SLOTS)) u_core (
    .slots    (slots),
    .slot_vld (slot_vld),
    .pc       (win_pc),
    .uop      (uop_c),
    .consumed (cons_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      uop_valid    <= 1'b0;
      uop_op       <= '0;
      uop_rs1      <= '0;
      uop_imm      <= '0;
      uop_rd       <= '0;
      uop_next_pc  <= '0;
      uop_alt_pc   <= '0;
      uop_consumed <= '0;
    end else begin
      uop_valid <= in_valid;
      if (in_valid) begin
        uop_op       <= uop_c.op;
        uop_rs1      <= uop_c.rs1;
        uop_imm      <= uop_c.imm;
        uop_rd       <= uop_c.rd;
        uop_next_pc  <= uop_c.next_pc;
        uop_alt_pc   <= uop_c.alt_pc;
        uop_consumed <= cons_c;
      end
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> uop_valid); // R1

  AST_IDLE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !uop_valid); // R1

  AST_BR_FALLTHROUGH: assert property (@(posedge clk) disable iff (rst)
    (uop_valid && uop_op == 3'(UOP_BR)) |->
      (uop_alt_pc == $past(win_pc) + 32'd4 && uop_consumed == CNT_W'(1))); // R7

  AST_PASS_SEQ: assert property (@(posedge clk) disable iff (rst)
    (uop_valid && uop_op == 3'(UOP_PASS)) |->
      (uop_next_pc == $past(win_pc) + 32'd4 && uop_consumed == CNT_W'(1))); // R8

  AST_ALT_EQ_NEXT: assert property (@(posedge clk) disable iff (rst)
    (uop_valid && uop_op != 3'(UOP_BR)) |-> (uop_alt_pc == uop_next_pc)); // R9

  AST_JMP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (uop_valid && uop_op == 3'(UOP_JMP)) |-> (uop_consumed == CNT_W'(1))); // R6

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    uop_valid |-> (uop_consumed >= CNT_W'(1) && uop_consumed <= $past(win_count))); // R11

endmodule

// File: tb/tb_rvf_fuse_decoder.sv
module tb_rvf_fuse_decoder;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [31:0]  win_pc;
  logic [127:0] win_insn;
  logic [2:0]   win_count;
  logic         uop_valid;
  logic [2:0]   uop_op;
  logic [4:0]   uop_rs1;
  logic [31:0]  uop_imm;
  logic [4:0]   uop_rd;
  logic [31:0]  uop_next_pc;
  logic [31:0]  uop_alt_pc;
  logic [2:0]   uop_consumed;

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] NOP = 32'h0000_0013;

  always #(CLK_PERIOD/2) clk = ~clk;

  rvf_fuse_decoder dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .win_pc(win_pc),
    .win_insn(win_insn), .win_count(win_count), .uop_valid(uop_valid),
    .uop_op(uop_op), .uop_rs1(uop_rs1), .uop_imm(uop_imm), .uop_rd(uop_rd),
    .uop_next_pc(uop_next_pc), .uop_alt_pc(uop_alt_pc),
    .uop_consumed(uop_consumed)
  );

  function automatic logic [31:0] e_lui(input logic [4:0] rd, input logic [19:0] i20);
    return {i20, rd, 7'b0110111};
  endfunction
  function automatic logic [31:0] e_addi(input logic [4:0] rd, input logic [4:0] rs1, input logic [11:0] i12);
    return {i12, rs1, 3'b000, rd, 7'b0010011};
  endfunction
  function automatic logic [31:0] e_jal(input logic [4:0] rd, input logic [20:0] o);
    return {o[20], o[10:1], o[11], o[19:12], rd, 7'b1101111};
  endfunction
  function automatic logic [31:0] e_br(input logic [2:0] f3, input logic [4:0] rs1, input logic [4:0] rs2, input logic [12:0] o);
    return {o[12], o[10:5], rs2, rs1, f3, o[4:1], o[11], 7'b1100011};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Present one window for one cycle; outputs are read at the following negedge.
  task automatic run(input logic [31:0] pc, input logic [31:0] i0, input logic [31:0] i1,
                     input logic [31:0] i2, input logic [31:0] i3, input logic [2:0] cnt);
    @(negedge clk);
    win_pc = pc; win_insn = {i3, i2, i1, i0}; win_count = cnt; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_uop(input string tag, input logic [2:0] op, input logic [4:0] rs1,
                            input logic [4:0] rd, input logic [31:0] imm, input logic [31:0] nxt,
                            input logic [31:0] alt, input logic [2:0] cons);
    chk({tag, " valid"}, 32'(uop_valid), 32'd1);
    chk({tag, " op"}, 32'(uop_op), 32'(op));
    chk({tag, " rs1"}, 32'(uop_rs1), 32'(rs1));
    chk({tag, " rd"}, 32'(uop_rd), 32'(rd));
    chk({tag, " imm"}, uop_imm, imm);
    chk({tag, " next"}, uop_next_pc, nxt);
    chk({tag, " alt"}, uop_alt_pc, alt);
    chk({tag, " consumed"}, 32'(uop_consumed), 32'(cons));
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b0; win_pc = '0; win_insn = '0; win_count = 3'd4;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset valid", 32'(uop_valid), 32'd0);
  endtask

  task automatic t_pair;
    run(32'h1000, e_lui(5'd5, 20'h12345), e_addi(5'd5, 5'd5, 12'h678), NOP, NOP, 3'd4);
    expect_uop("R2 pair", 3'd1, 5'd0, 5'd5, 32'h1234_5678, 32'h1008, 32'h1008, 3'd2);
    run(32'h2000, e_lui(5'd9, 20'h12345), e_addi(5'd9, 5'd9, 12'hFFF), NOP, NOP, 3'd4);
    expect_uop("R2 pair negative low", 3'd1, 5'd0, 5'd9, 32'h1234_4FFF, 32'h2008, 32'h2008, 3'd2);
  endtask

  task automatic t_nopair;
    run(32'h3000, e_lui(5'd5, 20'h12345), e_addi(5'd5, 5'd6, 12'h678), NOP, NOP, 3'd4);
    expect_uop("R3 rs1 mismatch", 3'd1, 5'd0, 5'd5, 32'h1234_5000, 32'h3004, 32'h3004, 3'd1);
    run(32'h3100, e_lui(5'd5, 20'h12345), e_addi(5'd6, 5'd5, 12'h678), NOP, NOP, 3'd4);
    expect_uop("R3 rd mismatch", 3'd1, 5'd0, 5'd5, 32'h1234_5000, 32'h3104, 32'h3104, 3'd1);
    run(32'h3200, e_lui(5'd5, 20'h12345), e_addi(5'd5, 5'd5, 12'h678), NOP, NOP, 3'd1);
    expect_uop("R11 pair beyond count", 3'd1, 5'd0, 5'd5, 32'h1234_5000, 32'h3204, 32'h3204, 3'd1);
  endtask

  // Pair fusion and jump absorption in the same window.
  task automatic t_triple;
    run(32'h4000, e_lui(5'd7, 20'hABCDE), e_addi(5'd7, 5'd7, 12'h123), e_jal(5'd0, 21'h100), NOP, 3'd4);
    expect_uop("R4 triple", 3'd1, 5'd0, 5'd7, 32'hABCD_E123, 32'h4108, 32'h4108, 3'd3);
    run(32'h5000, e_addi(5'd1, 5'd2, 12'hFF8), e_jal(5'd0, 21'h1FFFF0), NOP, NOP, 3'd4);
    expect_uop("R4 R10 addi+jump", 3'd2, 5'd2, 5'd1, 32'hFFFF_FFF8, 32'h4FF4, 32'h4FF4, 3'd2);
  endtask

  task automatic t_link;
    run(32'h5800, e_addi(5'd1, 5'd2, 12'h010), e_jal(5'd1, 21'h20), NOP, NOP, 3'd4);
    expect_uop("R5 R10 link not absorbed", 3'd2, 5'd2, 5'd1, 32'h10, 32'h5804, 32'h5804, 3'd1);
    run(32'h6000, e_jal(5'd1, 21'h40), NOP, NOP, NOP, 3'd4);
    expect_uop("R5 link head", 3'd1, 5'd0, 5'd1, 32'h6004, 32'h6040, 32'h6040, 3'd1);
  endtask

  task automatic t_jmp;
    run(32'h7000, e_jal(5'd0, 21'h1FF800), NOP, NOP, NOP, 3'd4);
    expect_uop("R6 plain jump", 3'd4, 5'd0, 5'd0, 32'h0, 32'h6800, 32'h6800, 3'd1);
  endtask

  task automatic t_branch;
    run(32'h8000, e_br(3'b001, 5'd3, 5'd4, 13'h1FF4), e_jal(5'd0, 21'h100), NOP, NOP, 3'd4);
    expect_uop("R7 branch", 3'd3, 5'd3, 5'd0, 32'h24, 32'h7FF4, 32'h8004, 3'd1);
  endtask

  task automatic t_pass;
    logic [31:0] add_w;
    add_w = {7'd0, 5'd3, 5'd2, 3'b000, 5'd1, 7'b0110011};
    run(32'h9000, add_w, e_jal(5'd0, 21'h100), NOP, NOP, 3'd4);
    expect_uop("R8 passthrough", 3'd0, 5'd2, 5'd1, add_w, 32'h9004, 32'h9004, 3'd1);
  endtask

  task automatic t_count_limit;
    run(32'hA000, e_addi(5'd4, 5'd4, 12'h001), e_jal(5'd0, 21'h80), NOP, NOP, 3'd1);
    expect_uop("R11 R9 jump beyond count", 3'd2, 5'd4, 5'd4, 32'h1, 32'hA004, 32'hA004, 3'd1);
    @(negedge clk);
    chk("R1 idle valid", 32'(uop_valid), 32'd0);
  endtask

  initial begin
    t_reset;
    t_pair;
    t_nopair;
    t_triple;
    t_link;
    t_jmp;
    t_branch;
    t_pass;
    t_count_limit;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule